// File: doc/BRIEF.md
# Strided Quadword DMA Sequencer

This block is the address and count engine of one DMA channel that moves data in 16-byte quadwords. Software loads a packed stride register (a skip count and a chunk count, each eight bits) over a small register bus. A channel start pulse then supplies a mode, a start address and a total quadword count. The engine issues one memory request per quadword through a request/ready handshake. It stops when the remaining count reaches zero.

In contiguous mode the addresses simply rise by 16 bytes per quadword. In strided mode the engine moves a chunk of quadwords. It then spends one cycle jumping the address forward by 16 bytes times the skip count, and repeats. If either stride field is zero, strided mode falls back to contiguous transfer. The stride fields and the mode are captured at start, so the register can be rewritten during a run without disturbing that run. A total count that is not a multiple of the chunk size shortens the final chunk and raises a sticky error flag.

Top module: `stride_dma_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and mem_req_o are 0 and the stride register reads back as 0.
- R2: A write to byte address 0x30 stores wdata[7:0] as the skip count and wdata[23:16] as the chunk count. A read at 0x30 returns these fields in the same positions, with bits 15:8 and 31:24 reading 0. A read at any other address returns 0.
- R3: Writes to byte addresses 0x34, 0x38 and 0x3C leave the stride register unchanged.
- R4: Mode 0 gives contiguous addresses. The k-th quadword (k from 0) is requested at madr + 16·k.
- R5: Mode 2 with both fields nonzero gives strided addresses. The k-th quadword is requested at madr + 16·(k + floor(k/chunk)·skip). Exactly one busy cycle with mem_req_o low separates consecutive chunks, and no such cycle follows the final chunk.
- R6: Mode 2 with a skip or chunk count of 0 behaves exactly like mode 0.
- R7: The address and the remaining count advance only on a cycle with mem_req_o and mem_rdy_i both high. While ready is low, the request stays high and mem_addr_o holds its value.
- R8: Exactly qwc requests are accepted. busy_o falls and done_o pulses for one cycle in the cycle after the final accept. A start with qwc = 0 pulses done_o without raising busy_o.
- R9: In strided mode with qwc not a multiple of the chunk count, the last chunk is truncated to the remaining count, with no extra requests. err_o then rises and stays high until reset.
- R10: While busy, start pulses are ignored. Register writes do not change the stride of the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address (write and read) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| ch_mode_i | input | 2 | Channel mode: 0 contiguous, 2 strided |
| ch_start_i | input | 1 | Start pulse, sampled when idle |
| ch_madr_i | input | 32 | Start byte address |
| ch_qwc_i | input | 16 | Total quadword count |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky truncated-final-chunk flag |
| mem_req_o | output | 1 | Quadword memory request |
| mem_addr_o | output | 32 | Request byte address |
| mem_rdy_i | input | 1 | Memory accepts the request this cycle |

## Verification
Two pairs of events can land on the same edge. The first is the end of a chunk and the end of the whole transfer, when qwc is an exact multiple of the chunk size. The second is the last accepted quadword and a truncated chunk, when it is not. The bench sweeps every skip and chunk value from 0 to 3 and every qwc from 0 to 7, in both modes, with and without random ready stalls. In the first pair, no gap cycle may follow the final accept, and done must come exactly one cycle after it. In the second, err must rise together with completion and the request count must still equal qwc. A further run rewrites the stride register and pulses start in the middle of a transfer; the address sequence is then compared with the original stride.

// File: rtl/stride_pkg.sv
package stride_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_SKIP} seq_st_e;
  localparam logic [1:0] MODE_LINEAR = 2'd0;
  localparam logic [1:0] MODE_STRIDE = 2'd2;
  localparam int QW_SHIFT = 4;
  localparam int FLD_W = 8;
  localparam int SKIP_LSB = 0;
  localparam int CHUNK_LSB = 16;
endpackage

// File: rtl/stride_reg.sv
module stride_reg
  import stride_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] SLOT_ADDR = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [FLD_W-1:0]  skip_o,
  output logic [FLD_W-1:0]  chunk_o
);
  logic [FLD_W-1:0] skip_q, chunk_q;
  logic hit_word0, hit_slot;

  assign hit_slot  = addr_i[REG_AW-1:4] == SLOT_ADDR[REG_AW-1:4];
  assign hit_word0 = hit_slot && (addr_i[3:0] == 4'h0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q  <= '0;
      chunk_q <= '0;
    end else if (wr_i && hit_word0) begin
      skip_q  <= wdata_i[SKIP_LSB +: FLD_W];
      chunk_q <= wdata_i[CHUNK_LSB +: FLD_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_word0) begin
      rdata_o[SKIP_LSB +: FLD_W]  = skip_q;
      rdata_o[CHUNK_LSB +: FLD_W] = chunk_q;
    end
  end

  assign skip_o  = skip_q;
  assign chunk_o = chunk_q;

  assert_write_fields_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_word0) |=> (skip_o == $past(wdata_i[SKIP_LSB +: FLD_W]))
                         && (chunk_o == $past(wdata_i[CHUNK_LSB +: FLD_W])));

  assert_upper_words_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_slot && addr_i[3:2] != 2'b00) |=> $stable({skip_o, chunk_o}));
endmodule

// File: rtl/stride_seq.sv
module stride_seq
  import stride_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [AW-1:0]    madr_i,
  input  logic [CW-1:0]    qwc_i,
  input  logic [FLD_W-1:0] skip_i,
  input  logic [FLD_W-1:0] chunk_i,
  input  logic             mem_rdy_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [AW-1:0] QW_BYTES = AW'(1) << QW_SHIFT;

  seq_st_e          st_q;
  logic [AW-1:0]    addr_q;
  logic [CW-1:0]    rem_q;
  logic [FLD_W-1:0] cnt_q, chunk_q, skip_q;
  logic             strided_q, done_q, err_q;
  logic             accept, last_qw, chunk_end, strided_req;
  logic [AW-1:0]    skip_bytes;

  assign strided_req = (mode_i == MODE_STRIDE) && (skip_i != '0) && (chunk_i != '0);
  assign accept      = (st_q == ST_XFER) && mem_rdy_i;
  assign last_qw     = rem_q == CW'(1);
  assign chunk_end   = strided_q && ({1'b0, cnt_q} + 1'b1 == {1'b0, chunk_q});
  assign skip_bytes  = AW'(skip_q) << QW_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      cnt_q     <= '0;
      chunk_q   <= '0;
      skip_q    <= '0;
      strided_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          addr_q    <= madr_i;
          rem_q     <= qwc_i;
          cnt_q     <= '0;
          chunk_q   <= chunk_i;
          skip_q    <= skip_i;
          strided_q <= strided_req;
          if (qwc_i == '0) done_q <= 1'b1;
          else             st_q   <= ST_XFER;
        end
        ST_XFER: if (accept) begin
          addr_q <= addr_q + QW_BYTES;
          rem_q  <= rem_q - 1'b1;
          cnt_q  <= cnt_q + 1'b1;
          if (last_qw) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            if (strided_q && !chunk_end) err_q <= 1'b1;
          end else if (chunk_end) begin
            st_q  <= ST_SKIP;
            cnt_q <= '0;
          end
        end
        ST_SKIP: begin
          addr_q <= addr_q + skip_bytes;
          st_q   <= ST_XFER;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = st_q == ST_XFER;
  assign mem_addr_o = addr_q;
  assign busy_o     = st_q != ST_IDLE;
  assign done_o     = done_q;
  assign err_o      = err_q;

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_contig_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rdy_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + QW_BYTES));

  assert_gap_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_req_o) |=> mem_req_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_req_needs_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !mem_req_o) |=> busy_o);
endmodule

// File: rtl/stride_dma_seq.sv
module stride_dma_seq
  import stride_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter logic [REG_AW-1:0] SLOT_ADDR = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [1:0]        ch_mode_i,
  input  logic              ch_start_i,
  input  logic [AW-1:0]     ch_madr_i,
  input  logic [CW-1:0]     ch_qwc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rdy_i
);
  logic [FLD_W-1:0] skip_w, chunk_w;

  stride_reg #(.REG_AW(REG_AW), .SLOT_ADDR(SLOT_ADDR)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .skip_o  (skip_w),
    .chunk_o (chunk_w)
  );

  stride_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ch_start_i),
    .mode_i     (ch_mode_i),
    .madr_i     (ch_madr_i),
    .qwc_i      (ch_qwc_i),
    .skip_i     (skip_w),
    .chunk_i    (chunk_w),
    .mem_rdy_i  (mem_rdy_i),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: tb/sim_stride_dma_seq.sv
`timescale 1ns/1ps
module sim_stride_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  mode = '0;
  logic        start = 1'b0;
  logic [31:0] madr = '0;
  logic [15:0] qwc = '0;
  logic        busy, done, err, req, rdy = 1'b1;
  logic [31:0] addr;
  logic [7:0]  lfsr = 8'hA5;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stride_dma_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ch_mode_i(mode),
    .ch_start_i(start), .ch_madr_i(madr), .ch_qwc_i(qwc), .busy_o(busy),
    .done_o(done), .err_o(err), .mem_req_o(req), .mem_addr_o(addr), .mem_rdy_i(rdy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; reg_wr = 1'b0; rdy = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic run(input logic [1:0] m, input int sk, input int ch, input int n,
                     input logic [31:0] base, input bit stall, input bit disturb);
    bit il;
    int k, gaps, dones, exp_gaps, it;
    logic [31:0] exp_a;
    il = (m == 2'd2) && sk != 0 && ch != 0;
    do_reset();
    wr_reg(8'h30, (32'(ch) << 16) | 32'(sk));
    @(negedge clk);
    mode = m; madr = base; qwc = 16'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; gaps = 0; dones = 0;
    for (it = 0; it < 300; it++) begin
      if (disturb && it == 1) begin
        reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h0;
        start = 1'b1; madr = 32'h8000; mode = 2'd0; qwc = 16'd9;
      end else if (disturb && it == 2) begin
        reg_wr = 1'b0; start = 1'b0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = stall ? lfsr[0] : 1'b1;
      #1;
      if (req && rdy) begin
        exp_a = il ? base + 32'(16 * (k + (k / ch) * sk)) : base + 32'(16 * k);
        chk(addr == exp_a, il ? (disturb ? "R10 addr" : "R5 addr")
                              : ((m == 2'd2) ? "R6 addr" : "R4 addr"), addr, exp_a);
        k++;
      end
      if (busy && !req) gaps++;
      if (done) begin
        dones++;
        chk(!busy, "R8 busy low with done", busy, 0);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    #1;
    chk(dones == 1, "R8 done pulses", dones, 1);
    chk(k == n, "R8 request count", k, n);
    chk(!done && !busy, "R8 idle after done", {done, busy}, 0);
    exp_gaps = (il && n > 0) ? ((n + ch - 1) / ch) - 1 : 0;
    chk(gaps == exp_gaps, il ? "R5 gap cycles" : "R6 no gaps", gaps, exp_gaps);
    chk(err == (il && (n % ch) != 0), "R9 err flag", err, il && (n % ch) != 0);
  endtask

  initial begin
    do_reset();
    #1;
    chk(!busy && !done && !err && !req, "R1 reset outputs", {busy, done, err, req}, 0);
    rd_chk(8'h30, 32'h0, "R1 reg reset");
    wr_reg(8'h30, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'h00FF_00FF, "R2 reserved zero");
    wr_reg(8'h30, 32'h1234_5678);
    rd_chk(8'h30, 32'h0034_0078, "R2 fields");
    rd_chk(8'h20, 32'h0, "R2 other addr");
    wr_reg(8'h34, 32'h00AA_00BB);
    rd_chk(8'h30, 32'h0034_0078, "R3 +4 ignored");
    wr_reg(8'h38, 32'h00CC_00DD);
    rd_chk(8'h30, 32'h0034_0078, "R3 +8 ignored");
    wr_reg(8'h3C, 32'h00EE_00FF);
    rd_chk(8'h30, 32'h0034_0078, "R3 +C ignored");

    for (int st = 0; st < 2; st++)
      for (int mi = 0; mi < 2; mi++)
        for (int sk = 0; sk < 4; sk++)
          for (int ch = 0; ch < 4; ch++)
            for (int n = 0; n < 8; n++)
              run(mi ? 2'd2 : 2'd0, sk, ch, n, 32'h0001_0000 + 32'(n << 8), st[0], 1'b0);

    // R7: long stalled contiguous run
    run(2'd0, 0, 0, 20, 32'h0000_4000, 1'b1, 1'b0);
    // R10: mid-run rewrite and start pulse
    run(2'd2, 1, 2, 4, 32'h0000_1000, 1'b0, 1'b1);
    run(2'd2, 3, 3, 7, 32'h0000_2000, 1'b1, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule